// File: doc/BRIEF.md
# BCD Calendar Counter with Snapshot

This block is the timekeeping core of a real-time clock. It keeps the time as six packed-BCD fields: second, minute, hour (held internally in 24-hour form), day of month, month and a two-digit year. A one-cycle tick arriving once a second advances the chain. Each field carries into the next when it wraps. The day field wraps at the length of the current month, and February gets a 29th day in years divisible by four.

Software reaches the block through a byte-wide register port with one address bus. A write strobe stores `wdata` at the next clock edge, and `rdata` always shows the register that `addr` selects. The control register holds four settings: a run gate, a 12/24-hour presentation mode, a snapshot request and a selector that steers time reads to a static shadow bank. Software halts the clock, loads a new time and restarts it. To read all six fields coherently while the clock keeps running, it requests a snapshot and then reads the shadow bank.

Two small state machines sit behind the control register. The run machine has the states HALTED and RUNNING. A control write with the run bit set takes the transition GO from HALTED to RUNNING. A control write with the run bit clear takes the transition STOP back to HALTED. The snapshot machine has the states IDLE and ARMED. A control write with the snapshot bit set takes the transition ARM from IDLE to ARMED, and the shadow copy happens on that same clock edge. A control write with the snapshot bit clear takes the transition DISARM back to IDLE. Four pulse outputs report the rollovers to a neighbouring event block.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, reads return 0x00 for second, minute, hour and year, 0x01 for day and month, and 0x00 for control and status. All pulse outputs are low.
- R2: While the clock is halted, ticks change nothing. A write to offset 0 (second), 1 (minute), 2 (hour), 3 (day), 4 (month) or 5 (year) loads that field at the next edge.
- R3: While running, each tick advances the seconds in BCD. Seconds wrap 59→00 and carry into minutes. Minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and carry into the day.
- R4: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In February it wraps after 29 when the year value is divisible by 4, and after 28 otherwise. The month wraps 12→01 and carries into the year, and the year wraps 99→00.
- R5: A write to any time field while the clock runs is ignored.
- R6: A written time value is first limited digit by digit: any nibble above 9 becomes 9. It is then limited to the field's range: second and minute 00–59, hour 00–23, day 01–31, month 01–12, year 00–99.
- R7: The control register sits at offset 7. A control write with bit 6 set, made while bit 6 was clear, copies all six live fields into the shadow bank at that edge. Writing bit 6 set again while it is already set makes no new copy. While control bit 7 is set, time reads return the shadow bank.
- R8: While control bit 3 is set, the hour reads as BCD 01–12, with bit 7 set for the afternoon hours 12–23. Hour writes in this mode are taken in the same format.
- R9: The status register sits at offset 8. Its bit 1 reads 1 exactly while the clock runs, and its other bits read 0.
- R10: `ev_pulse` bit 0 marks each counted second, bit 1 a seconds wrap, bit 2 a minutes wrap and bit 3 an hours wrap. Each pulse is high for one cycle, the first cycle that shows the new count.
- R11: Offset 6 reads 0x00 and ignores writes. Control bits 1, 2, 4 and 5 read 0.
- R12: Control bit 0 runs the clock: GO sets it and STOP clears it. The control register reads back the run, mode, snapshot and shadow-select bits as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ev_pulse | output | 4 | Rollover pulses: second, minute, hour, day |

## Verification
A wrong carry or a wrong month-length decision stays hidden until the tick that crosses the boundary. It then shows at once in two places: a wrong pulse pattern on `ev_pulse` in the cycle after that tick, and a wrong field on the next read. The bench therefore drives times right up to each boundary and checks the pulses on every tick. A broken snapshot or run state machine shows on the very next read, as a shadow value that should or should not have moved, or as a wrong status bit. Random loads followed by long tick runs catch anything the directed cases miss, within a few hundred cycles.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int NUM_EVENTS = 4;

    localparam int FI_SEC  = 0;
    localparam int FI_MIN  = 1;
    localparam int FI_HOUR = 2;
    localparam int FI_DAY  = 3;
    localparam int FI_MON  = 4;
    localparam int FI_YEAR = 5;

    localparam int CB_RUN    = 0;
    localparam int CB_H12    = 3;
    localparam int CB_SNAP   = 6;
    localparam int CB_SHADOW = 7;
    localparam int SB_RUN    = 1;

    typedef logic [7:0] bcd_t;

    typedef enum logic {ST_HALTED, ST_RUNNING} run_state_e;
    typedef enum logic {SN_IDLE, SN_ARMED} snap_state_e;

    function automatic logic [3:0] nib_sat(input logic [3:0] n);
        return (n > 4'd9) ? 4'd9 : n;
    endfunction

    function automatic logic [7:0] bcd_to_bin(input bcd_t v);
        logic [7:0] t, o;
        t = {4'd0, v[7:4]};
        o = {4'd0, v[3:0]};
        return t * 8'd10 + o;
    endfunction

    function automatic bcd_t bin_to_bcd(input logic [7:0] b);
        logic [7:0] t, o;
        t = b / 8'd10;
        o = b % 8'd10;
        return {t[3:0], o[3:0]};
    endfunction

    function automatic bcd_t bcd_inc(input bcd_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] field_min(input logic [2:0] idx);
        case (idx)
            3'd3, 3'd4: return 8'd1;
            default:    return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] field_max(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1: return 8'd59;
            3'd2:       return 8'd23;
            3'd3:       return 8'd31;
            3'd4:       return 8'd12;
            default:    return 8'd99;
        endcase
    endfunction

    function automatic bcd_t field_clamp(input logic [2:0] idx, input bcd_t v);
        logic [7:0] b;
        b = bcd_to_bin({nib_sat(v[7:4]), nib_sat(v[3:0])});
        if (b < field_min(idx))      b = field_min(idx);
        else if (b > field_max(idx)) b = field_max(idx);
        return bin_to_bcd(b);
    endfunction

    function automatic bcd_t month_len(input bcd_t mon, input bcd_t yr);
        logic [7:0] yb;
        yb = bcd_to_bin(yr);
        case (mon)
            8'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic bcd_t hour_to_12(input bcd_t h24);
        logic [7:0] b, r;
        logic       pm;
        bcd_t       y;
        b  = bcd_to_bin(h24);
        pm = (b >= 8'd12);
        r  = pm ? b - 8'd12 : b;
        if (r == 8'd0) r = 8'd12;
        y = bin_to_bcd(r);
        return {pm, 2'b00, y[4:0]};
    endfunction

    function automatic bcd_t hour_from_12(input bcd_t v);
        logic [7:0] b, r;
        b = bcd_to_bin({1'b0, v[6:4], nib_sat(v[3:0])});
        if (b < 8'd1)       b = 8'd1;
        else if (b > 8'd12) b = 8'd12;
        r = (b == 8'd12) ? 8'd0 : b;
        if (v[7]) r = r + 8'd12;
        return bin_to_bcd(r);
    endfunction

endpackage

// File: rtl/rtc_ctrl_fsm.sv
module rtc_ctrl_fsm
    import rtc_bcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic req_run,
    input  logic req_snap,
    output logic running,
    output logic snap_armed,
    output logic capture
);

    run_state_e  run_q, run_d;
    snap_state_e snap_q, snap_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= ST_HALTED;
            snap_q <= SN_IDLE;
        end else begin
            run_q  <= run_d;
            snap_q <= snap_d;
        end
    end

    always_comb begin
        run_d  = run_q;
        snap_d = snap_q;
        unique case (run_q)
            ST_HALTED:  if (ctrl_wr && req_run)  run_d = ST_RUNNING;  // GO
            ST_RUNNING: if (ctrl_wr && !req_run) run_d = ST_HALTED;   // STOP
        endcase
        unique case (snap_q)
            SN_IDLE:  if (ctrl_wr && req_snap)  snap_d = SN_ARMED;    // ARM
            SN_ARMED: if (ctrl_wr && !req_snap) snap_d = SN_IDLE;     // DISARM
        endcase
    end

    always_comb begin
        running    = (run_q == ST_RUNNING);
        snap_armed = (snap_q == SN_ARMED);
        capture    = (snap_q == SN_IDLE) && ctrl_wr && req_snap;
    end

endmodule

// File: rtl/rtc_counter_chain.sv
module rtc_counter_chain
    import rtc_bcd_pkg::*;
#(
    parameter int NF = NUM_FIELDS,
    parameter int NE = NUM_EVENTS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [NF-1:0]       load_en,
    input  bcd_t                load_val,
    output logic [NF-1:0][7:0]  flds,
    output logic [NE-1:0]       ev
);

    bcd_t        fld_q [NF];
    logic [NF-1:0] carry;

    assign carry[0] = step;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        bcd_t lim;
        logic wrap;
        if (i == FI_DAY) begin : g_dyn
            assign lim = month_len(fld_q[FI_MON], fld_q[FI_YEAR]);
        end else begin : g_fix
            assign lim = bin_to_bcd(field_max(3'(i)));
        end
        assign wrap = (fld_q[i] >= lim);
        if (i < NF - 1) begin : g_cy
            assign carry[i+1] = carry[i] && wrap;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          fld_q[i] <= field_min(3'(i));
            else if (load_en[i]) fld_q[i] <= load_val;
            else if (carry[i])   fld_q[i] <= wrap ? field_min(3'(i)) : bcd_inc(fld_q[i]);
        end
        assign flds[i] = fld_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev <= '0;
        else        ev <= carry[NE-1:0];
    end

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_bcd_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFS = 7,
    parameter int STAT_OFS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [3:0]        ev_pulse
);

    localparam int NF = NUM_FIELDS;

    logic [NF-1:0][7:0] live_flds;
    bcd_t               shadow_q [NF];
    logic [NF-1:0]      load_en;
    bcd_t               load_val;
    logic               running, snap_armed, capture, ctrl_wr;
    logic               h12_q, shsel_q;

    assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_OFS));

    rtc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .req_run    (wdata[CB_RUN]),
        .req_snap   (wdata[CB_SNAP]),
        .running    (running),
        .snap_armed (snap_armed),
        .capture    (capture)
    );

    always_comb begin
        for (int i = 0; i < NF; i++)
            load_en[i] = wr_en && !running && (addr == ADDR_W'(i));
        if ((addr == ADDR_W'(FI_HOUR)) && h12_q) load_val = hour_from_12(wdata);
        else                                    load_val = field_clamp(addr[2:0], wdata);
    end

    rtc_counter_chain #(.NF(NF), .NE(NUM_EVENTS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick_1hz && running),
        .load_en  (load_en),
        .load_val (load_val),
        .flds     (live_flds),
        .ev       (ev_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h12_q   <= 1'b0;
            shsel_q <= 1'b0;
        end else if (ctrl_wr) begin
            h12_q   <= wdata[CB_H12];
            shsel_q <= wdata[CB_SHADOW];
        end
    end

    for (genvar i = 0; i < NF; i++) begin : g_shadow
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       shadow_q[i] <= field_min(3'(i));
            else if (capture) shadow_q[i] <= live_flds[i];
        end
    end

    always_comb begin
        bcd_t src;
        src   = 8'h00;
        rdata = 8'h00;
        for (int i = 0; i < NF; i++)
            if (addr == ADDR_W'(i)) src = shsel_q ? shadow_q[i] : live_flds[i];
        if (addr < ADDR_W'(NF)) begin
            rdata = ((addr == ADDR_W'(FI_HOUR)) && h12_q) ? hour_to_12(src) : src;
        end else if (addr == ADDR_W'(CTRL_OFS)) begin
            rdata[CB_RUN]    = running;
            rdata[CB_H12]    = h12_q;
            rdata[CB_SNAP]   = snap_armed;
            rdata[CB_SHADOW] = shsel_q;
        end else if (addr == ADDR_W'(STAT_OFS)) begin
            rdata[SB_RUN] = running;
        end
    end

endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        ev_pulse,
    input logic              running,
    input logic [7:0]        sec_q,
    input logic [7:0]        day_q,
    input logic [7:0]        mon_q
);

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(wr_en && addr == '0)) |=> $stable(sec_q));

    assert_min_needs_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[1] |-> ev_pulse[0]);

    assert_carry_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse[3] |-> ev_pulse[2]) and (ev_pulse[2] |-> ev_pulse[1]));

    assert_month_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q >= 8'h01) && (mon_q <= 8'h12) && (mon_q[3:0] <= 4'd9));

    assert_day_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (day_q >= 8'h01) && (day_q <= 8'h31) && (day_q[3:0] <= 4'd9));

    assert_run_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && addr == '0 && !tick_1hz) |=> $stable(sec_q));

    assert_sec_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q <= 8'h59) && (sec_q[3:0] <= 4'd9));

    assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[0] |-> $past(tick_1hz && running));

endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .wr_en    (wr_en),
    .addr     (addr),
    .ev_pulse (ev_pulse),
    .running  (running),
    .sec_q    (live_flds[0]),
    .day_q    (live_flds[3]),
    .mon_q    (live_flds[4])
);

// File: tb/sim_rtc_bcd_core.sv
`timescale 1ns/1ps
module sim_rtc_bcd_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] ev_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int ms, mn, mh, md, mo, my;

    always #5 clk = ~clk;

    rtc_bcd_core u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ev_pulse(ev_pulse)
    );

    function automatic logic [7:0] tb_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int tb_mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_tick(output logic [3:0] e);
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        e = ev_pulse;
    endtask

    function automatic logic [3:0] model_tick();
        logic [3:0] e;
        e = 4'b0001;
        ms++;
        if (ms > 59) begin
            ms = 0; e[1] = 1'b1; mn++;
            if (mn > 59) begin
                mn = 0; e[2] = 1'b1; mh++;
                if (mh > 23) begin
                    mh = 0; e[3] = 1'b1; md++;
                    if (md > tb_mlen(mo, my)) begin
                        md = 1; mo++;
                        if (mo > 12) begin mo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
        return e;
    endfunction

    task automatic load_time(input int s, input int mi, input int h, input int d, input int m, input int y);
        wr(4'd0, tb_bcd(s)); wr(4'd1, tb_bcd(mi)); wr(4'd2, tb_bcd(h));
        wr(4'd3, tb_bcd(d)); wr(4'd4, tb_bcd(m)); wr(4'd5, tb_bcd(y));
        ms = s; mn = mi; mh = h; md = d; mo = m; my = y;
    endtask

    task automatic check_time(input string req);
        logic [7:0] v;
        rd(4'd0, v); chk(req, v, tb_bcd(ms));
        rd(4'd1, v); chk(req, v, tb_bcd(mn));
        rd(4'd2, v); chk(req, v, tb_bcd(mh));
        rd(4'd3, v); chk(req, v, tb_bcd(md));
        rd(4'd4, v); chk(req, v, tb_bcd(mo));
        rd(4'd5, v); chk(req, v, tb_bcd(my));
    endtask

    task automatic tick_check(input string req);
        logic [3:0] e, x;
        do_tick(e);
        x = model_tick();
        chk(req, {4'd0, e}, {4'd0, x});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [3:0] e;
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        ms = 0; mn = 0; mh = 0; md = 1; mo = 1; my = 0;
        check_time("R1");
        rd(4'd7, v); chk("R1", v, 8'h00);
        rd(4'd8, v); chk("R1", v, 8'h00);
        chk("R1", {4'd0, ev_pulse}, 8'h00);
        rd(4'd6, v); chk("R11", v, 8'h00);

        // R2 halted ticks ignored, loads accepted
        for (int k = 0; k < 3; k++) begin do_tick(e); chk("R2", {4'd0, e}, 8'h00); end
        check_time("R2");
        load_time(58, 59, 23, 31, 12, 99);
        check_time("R2");

        // R12 / R9 run gate and status
        wr(4'd7, 8'h01);
        rd(4'd8, v); chk("R9", v, 8'h02);
        rd(4'd7, v); chk("R12", v, 8'h01);

        // R3 R4 R10 full rollover
        tick_check("R10");
        tick_check("R3");
        check_time("R4");
        @(negedge clk); chk("R10", {4'd0, ev_pulse}, 8'h00);

        // R5 write while running ignored
        wr(4'd0, 8'h30); wr(4'd4, 8'h07);
        check_time("R5");

        // R4 month lengths
        wr(4'd7, 8'h00);
        rd(4'd8, v); chk("R9", v, 8'h00);
        load_time(59, 59, 23, 28, 2, 24); wr(4'd7, 8'h01);
        tick_check("R4"); check_time("R4");
        wr(4'd7, 8'h00); load_time(59, 59, 23, 29, 2, 24); wr(4'd7, 8'h01);
        tick_check("R4"); check_time("R4");
        wr(4'd7, 8'h00); load_time(59, 59, 23, 28, 2, 23); wr(4'd7, 8'h01);
        tick_check("R4"); check_time("R4");
        wr(4'd7, 8'h00); load_time(59, 59, 23, 30, 4, 10); wr(4'd7, 8'h01);
        tick_check("R4"); check_time("R4");
        wr(4'd7, 8'h00); load_time(59, 59, 23, 30, 1, 10); wr(4'd7, 8'h01);
        tick_check("R4"); check_time("R4");

        // R6 clamping while halted
        wr(4'd7, 8'h00);
        wr(4'd0, 8'h7A); rd(4'd0, v); chk("R6", v, 8'h59);
        wr(4'd1, 8'h1C); rd(4'd1, v); chk("R6", v, 8'h19);
        wr(4'd2, 8'h3F); rd(4'd2, v); chk("R6", v, 8'h23);
        wr(4'd3, 8'h45); rd(4'd3, v); chk("R6", v, 8'h31);
        wr(4'd3, 8'h00); rd(4'd3, v); chk("R6", v, 8'h01);
        wr(4'd4, 8'h00); rd(4'd4, v); chk("R6", v, 8'h01);
        wr(4'd4, 8'h13); rd(4'd4, v); chk("R6", v, 8'h12);
        wr(4'd5, 8'hFF); rd(4'd5, v); chk("R6", v, 8'h99);

        // R11 week slot and reserved control bits
        wr(4'd6, 8'h55); rd(4'd6, v); chk("R11", v, 8'h00);
        wr(4'd7, 8'h36); rd(4'd7, v); chk("R11", v, 8'h00);
        wr(4'd7, 8'h00);

        // R7 snapshot
        load_time(30, 20, 10, 15, 6, 21);
        wr(4'd7, 8'h41);
        for (int k = 0; k < 5; k++) tick_check("R3");
        wr(4'd7, 8'hC1);
        rd(4'd0, v); chk("R7", v, 8'h30);
        rd(4'd1, v); chk("R7", v, 8'h20);
        rd(4'd7, v); chk("R12", v, 8'hC1);
        wr(4'd7, 8'h81);
        rd(4'd0, v); chk("R7", v, 8'h30);
        wr(4'd7, 8'hC1);
        rd(4'd0, v); chk("R7", v, tb_bcd(ms));
        tick_check("R3");
        rd(4'd0, v); chk("R7", v, tb_bcd(ms - 1));
        wr(4'd7, 8'h41);
        rd(4'd0, v); chk("R7", v, tb_bcd(ms));

        // R8 12-hour presentation
        wr(4'd7, 8'h00);
        wr(4'd2, 8'h00); wr(4'd7, 8'h08); rd(4'd2, v); chk("R8", v, 8'h12);
        wr(4'd7, 8'h00); wr(4'd2, 8'h13); wr(4'd7, 8'h08); rd(4'd2, v); chk("R8", v, 8'h81);
        wr(4'd7, 8'h00); wr(4'd2, 8'h12); wr(4'd7, 8'h08); rd(4'd2, v); chk("R8", v, 8'h92);
        wr(4'd2, 8'h87); wr(4'd7, 8'h00); rd(4'd2, v); chk("R8", v, 8'h19);
        wr(4'd7, 8'h08); wr(4'd2, 8'h12); wr(4'd7, 8'h00); rd(4'd2, v); chk("R8", v, 8'h00);
        wr(4'd7, 8'h08); wr(4'd2, 8'h09); wr(4'd7, 8'h00); rd(4'd2, v); chk("R8", v, 8'h09);

        // random loads and tick runs
        for (int it = 0; it < 25; it++) begin
            int s, mi, h, d, m, y, n;
            m = 1 + int'($urandom % 12);
            y = int'($urandom % 100);
            if ($urandom % 2 == 0) begin
                s = 59 - int'($urandom % 3); mi = 59; h = 23; d = tb_mlen(m, y);
            end else begin
                s = int'($urandom % 60); mi = int'($urandom % 60);
                h = int'($urandom % 24); d = 1 + int'($urandom % tb_mlen(m, y));
            end
            wr(4'd7, 8'h00);
            load_time(s, mi, h, d, m, y);
            wr(4'd7, 8'h01);
            n = 1 + int'($urandom % 80);
            for (int k = 0; k < n; k++) tick_check("R10");
            check_time("R3");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule